// File: doc/BRIEF.md
# Three-Pin GPIO Port with PWM Input Override

This block controls three bidirectional general-purpose pins through a byte-wide register port. Software writes a control register that chooses, pin by pin, whether each pin is driven or only sampled, and a data register that holds the levels to drive. Pin levels coming back from the pads go through a synchronizer before anything in the block uses them.

Pin 0 has a second role. When the PWM-enable bit in the control register is set, pin 0 is forced to be an input whatever its own direction bit says. Its synchronized level then appears on a dedicated output that feeds downstream dimming logic. A read of the data register always returns the synchronized level of each pin, not the stored drive value, so software can see the real pad state in either direction.

The register port is synchronous: a write takes effect at the clock edge where the write strobe is high, and read data is a combinational view of the addressed register.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset, pinOe, pinOut and pwmLevel are all 0, and the control register reads 0x00.
- R2: The control register is at address 0x06. Bits 2:0 are the direction bits of pins 2:0 (1 = drive), bit 3 is the PWM enable, and bits 7:4 read as 0 whatever was written.
- R3: One clock edge after a control write, pinOe[i] equals the written direction bit i for each pin, with pin 0 included only while the PWM enable is 0.
- R4: While the PWM enable is 1, pinOe[0] is 0 whatever direction bit 0 holds. Clearing the PWM enable gives pin 0 back the value of direction bit 0.
- R5: The data register is at address 0x07, and bits 2:0 hold the drive values of pins 2:0. One clock edge after a write, pinOut shows the written bits.
- R6: A read of address 0x07 returns the pin levels in bits 2:0, for outputs and inputs alike, two clock edges after a pin changes. Bits 7:3 read as 0.
- R7: pwmLevel equals the synchronized pin 0 level while the PWM enable is 1, and is 0 while it is 0.
- R8: A data write to a pin set as input is stored. The stored value shows on pinOut and is driven as soon as the pin is set to output.
- R9: Reads of any address other than 0x06 and 0x07 return 0x00. Writes there leave pinOe, pinOut and pwmLevel unchanged.
- R10: The PWM enable does not change the direction of pins 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, sampled on the rising edge |
| regRdData | output | 8 | Read data of the addressed register |
| pinIn | input | 3 | Levels sampled from the pads |
| pinOut | output | 3 | Drive values toward the pads |
| pinOe | output | 3 | Per-pin drive enable |
| pwmLevel | output | 1 | Synchronized pin 0 level while PWM is enabled, else 0 |

## Verification
Register writes change pinOe, pinOut and the control readback one clock edge after the strobe. A pin change reaches data-register reads and pwmLevel only after the second edge, because of the two synchronizer flops. Inputs are driven on the falling edge, and every table vector is held for two rising edges before its outputs are sampled on the next falling edge, which covers both delays. A directed test samples a pin change after one edge and again after two edges, to confirm that the result is not early and not late.

// File: rtl/gpio_pwm_pkg.sv
package gpio_pwm_pkg;
  // Decoded access strobes handed from the address decoder to the pin datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrData;
    logic rdCtrl;
    logic rdData;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_regdecode.sv
module gpio_regdecode
  import gpio_pwm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 6,
  parameter int DATA_ADDR = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output gpioStrobe_t       strb
);
  localparam logic [ADDR_W-1:0] CtrlSel = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DataSel = ADDR_W'(DATA_ADDR);

  logic hitCtrl;
  logic hitData;

  assign hitCtrl = (regAddr == CtrlSel);
  assign hitData = (regAddr == DataSel);

  always_comb begin
    strb.rdCtrl = hitCtrl;
    strb.rdData = hitData;
    strb.wrCtrl = hitCtrl && regWrEn;
    strb.wrData = hitData && regWrEn;
  end

  // R9: an address outside the map raises no strobe
  a_r9_no_stray_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != CtrlSel && regAddr != DataSel) |-> (strb == '0));

  // R9: at most one write strobe at a time
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrData}));
endmodule

// File: rtl/gpio_pinpath.sv
module gpio_pinpath
  import gpio_pwm_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobe_t         strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                pwmLevel
);
  localparam int PwmBit = NUM_PINS;

  logic [NUM_PINS-1:0] oenReg;
  logic                pwmEn;
  logic [NUM_PINS-1:0] driveReg;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinSync;
  logic [DATA_W-1:0]   ctrlView;
  logic [DATA_W-1:0]   pinView;
  logic                unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:PwmBit+1];

  // Control and drive registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oenReg   <= '0;
      pwmEn    <= 1'b0;
      driveReg <= '0;
    end else begin
      if (strb.wrCtrl) begin
        oenReg <= wrData[NUM_PINS-1:0];
        pwmEn  <= wrData[PwmBit];
      end
      if (strb.wrData) begin
        driveReg <= wrData[NUM_PINS-1:0];
      end
    end
  end

  // Pad input synchronizer
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain[g] <= '0;
      end else begin
        if (g == 0) syncChain[g] <= pinIn;
        else        syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
      end
    end
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  // Direction: PWM mode takes pin 0 away from the output driver
  for (genvar p = 0; p < NUM_PINS; p++) begin : gDir
    if (p == 0) begin : gPwmPin
      assign pinOe[p] = oenReg[p] & ~pwmEn;
    end else begin : gPlainPin
      assign pinOe[p] = oenReg[p];
    end
  end

  assign pinOut   = driveReg;
  assign pwmLevel = pwmEn & pinSync[0];

  // Readback
  always_comb begin
    ctrlView                 = '0;
    ctrlView[NUM_PINS-1:0]   = oenReg;
    ctrlView[PwmBit]         = pwmEn;
    pinView                  = '0;
    pinView[NUM_PINS-1:0]    = pinSync;
    if (strb.rdCtrl)      rdData = ctrlView;
    else if (strb.rdData) rdData = pinView;
    else                  rdData = '0;
  end

  // Cycles since reset, for the latency check
  logic [3:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     warmCnt <= '0;
    else if (warmCnt < 4'(SYNC_STAGES)) warmCnt <= warmCnt + 4'd1;
  end

  a_r4_pwm_forces_input: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && wrData[PwmBit]) |=> !pinOe[0]);

  a_r3_dir_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> pinOe[NUM_PINS-1:1] == $past(wrData[NUM_PINS-1:1]));

  a_r5_drive_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> pinOut == $past(wrData[NUM_PINS-1:0]));

  a_r9_dir_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable(pinOe));

  a_r9_drive_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> $stable(pinOut));

  a_r7_pwm_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && !wrData[PwmBit]) |=> !pwmLevel);

  a_r6_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 4'(SYNC_STAGES) && strb.rdData) |->
      rdData[NUM_PINS-1:0] == $past(pinIn, SYNC_STAGES));
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port
  import gpio_pwm_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CTRL_ADDR   = 6,
  parameter int DATA_ADDR   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regWrEn,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                pwmLevel
);
  gpioStrobe_t strb;

  gpio_regdecode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  gpio_pinpath #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rdData(regRdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .pwmLevel(pwmLevel)
  );
endmodule

// File: tb/gpio_pwm_port_tb.sv
module gpio_pwm_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic [2:0] pinIn = '0;
  logic [2:0] pinOut;
  logic [2:0] pinOe;
  logic       pwmLevel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_pwm_port u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pwmLevel(pwmLevel)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] wd;
    logic       we;
    logic [2:0] pin;
    logic [2:0] eOe;
    logic [2:0] eOut;
    logic       ePwm;
    logic [7:0] eRd;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'h06, 8'h07, 1'b1, 3'b000, 3'b111, 3'b000, 1'b0, 8'h07, 4'd3},  // R3
    '{8'h07, 8'h05, 1'b1, 3'b000, 3'b111, 3'b101, 1'b0, 8'h00, 4'd5},  // R5
    '{8'h07, 8'h00, 1'b0, 3'b110, 3'b111, 3'b101, 1'b0, 8'h06, 4'd6},  // R6 outputs read pads
    '{8'h06, 8'h0F, 1'b1, 3'b110, 3'b110, 3'b101, 1'b0, 8'h0F, 4'd4},  // R4
    '{8'h07, 8'h00, 1'b0, 3'b111, 3'b110, 3'b101, 1'b1, 8'h07, 4'd7},  // R7
    '{8'h06, 8'h08, 1'b1, 3'b111, 3'b000, 3'b101, 1'b1, 8'h08, 4'd7},  // R7
    '{8'h07, 8'h02, 1'b1, 3'b001, 3'b000, 3'b010, 1'b1, 8'h01, 4'd8},  // R8 stored
    '{8'h06, 8'h06, 1'b1, 3'b001, 3'b110, 3'b010, 1'b0, 8'h06, 4'd8},  // R8 shows
    '{8'h10, 8'hFF, 1'b1, 3'b001, 3'b110, 3'b010, 1'b0, 8'h00, 4'd9},  // R9
    '{8'h06, 8'hF1, 1'b1, 3'b001, 3'b001, 3'b010, 1'b0, 8'h01, 4'd2},  // R2
    '{8'h05, 8'hFF, 1'b1, 3'b001, 3'b001, 3'b010, 1'b0, 8'h00, 4'd9},  // R9
    '{8'h07, 8'h00, 1'b0, 3'b100, 3'b001, 3'b010, 1'b0, 8'h04, 4'd6}   // R6 inputs
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    regAddr = 8'h06;
    #1;
    check("R1 oe", {5'd0, pinOe}, 8'h00);
    check("R1 out", {5'd0, pinOut}, 8'h00);
    check("R1 pwm", {7'd0, pwmLevel}, 8'h00);
    check("R1 ctrl", regRdData, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      regAddr = VECS[i].addr; regWrData = VECS[i].wd;
      regWrEn = VECS[i].we;   pinIn = VECS[i].pin;
      @(negedge clk);
      regWrEn = 1'b0;
      @(negedge clk);
      #1;
      check($sformatf("R%0d vec%0d oe", VECS[i].req, i), {5'd0, pinOe}, {5'd0, VECS[i].eOe});
      check($sformatf("R%0d vec%0d out", VECS[i].req, i), {5'd0, pinOut}, {5'd0, VECS[i].eOut});
      check($sformatf("R%0d vec%0d pwm", VECS[i].req, i), {7'd0, pwmLevel}, {7'd0, VECS[i].ePwm});
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), regRdData, VECS[i].eRd);
    end

    // R6: pad change seen after exactly two edges
    regAddr = 8'h07; pinIn = 3'b000;
    repeat (3) @(negedge clk);
    pinIn = 3'b011;
    @(negedge clk); #1;
    check("R6 one edge", regRdData, 8'h00);
    @(negedge clk); #1;
    check("R6 two edges", regRdData, 8'h03);

    // R4: PWM enable overrides direction bit 0, clearing it restores it
    regWrite(8'h06, 8'h09);
    #1;
    check("R4 override", {5'd0, pinOe}, 8'h00);
    regWrite(8'h06, 8'h01);
    #1;
    check("R4 restore", {5'd0, pinOe}, 8'h01);

    // R10: pins 1 and 2 keep their direction under PWM
    regWrite(8'h06, 8'h0E);
    #1;
    check("R10 pins12", {5'd0, pinOe}, 8'h06);
    regWrite(8'h06, 8'h08);
    #1;
    check("R10 pins12 off", {5'd0, pinOe}, 8'h00);

    // R7: pwmLevel follows pin 0 while enabled
    pinIn = 3'b001;
    repeat (2) @(negedge clk); #1;
    check("R7 high", {7'd0, pwmLevel}, 8'h01);
    pinIn = 3'b000;
    repeat (2) @(negedge clk); #1;
    check("R7 low", {7'd0, pwmLevel}, 8'h00);

    // R1: reset mid-run clears everything
    regWrite(8'h07, 8'h07);
    regWrite(8'h06, 8'h07);
    rstN = 1'b0;
    regAddr = 8'h06;
    #1;
    check("R1 rerst oe", {5'd0, pinOe}, 8'h00);
    check("R1 rerst out", {5'd0, pinOut}, 8'h00);
    check("R1 rerst ctrl", regRdData, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule